// File: doc/BRIEF.md
# GPIO Port with Halt Wake-Up Detection

This block is an 8-bit general-purpose I/O port for a small microcontroller, reached through a simple register bus. Each pin has a direction bit, an output data latch and a synchronized input path. The pad drivers are enabled for the pins that are configured as outputs. A read of the data register returns the latch for output pins and the synchronized pad level for input pins.

While the device is halted, each pin whose wake-up is enabled raises a wake request on a falling edge. Two pins, chosen by parameters, wake on either edge. When one of these two pins causes a wake, a sticky flag records it. Reading the flag register clears the flags. The wake request goes to the power controller, which owns the clock gating.

Top module: `gpio_wake_port`

## Requirements
- R1: A direction bit of 1 makes its pin an input and a 0 makes it an output. `pad_oe` is the inverse of the direction register and `pad_out` equals the data latch. Both follow a write on the cycle after the write edge.
- R2: After a synchronous reset, the data latch and the direction register are all ones. The wake-enable register and the wake-source flags are zero, `pad_oe` is 0 and `wake_req` is low.
- R3: A read of address 0 returns the latch bit for each output pin and the pad level for each input pin. A pad change shows up in read data after two clock edges, because of the synchronizer.
- R4: Address 2 holds the wake-enable mask, which can be written and read back. While `halt` is high, a falling edge on an enabled pin drives `wake_req` high for exactly one cycle, in the cycle after the second clock edge that follows the pad change. Nothing is requested for a pin that is not enabled, while `halt` is low, or on a rising edge of a single-edge pin.
- R5: The two dual-edge pins (parameters `DUAL_A`/`DUAL_B`, default 4 and 5) also request wake-up on a rising edge.
- R6: Address 3 reads the wake-source flags. Bit 0 is set when pin `DUAL_A` causes a wake while halted, and bit 1 when pin `DUAL_B` does. The upper bits read 0, and wakes from other pins set no flag.
- R7: A read of address 3 returns the current flags and then clears them at that clock edge.
- R8: When a wake event and a read of the flags fall on the same cycle, the flag ends up set.
- R9: Writes to address 3 neither set nor clear any flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 2 | Register address: 0 data, 1 direction, 2 wake enable, 3 wake source |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe; clears the flags when addr is 3 |
| rd_data | output | 8 | Combinational read data for addr |
| halt | input | 1 | Device is halted; gates wake requests and flag setting |
| pad_in | input | 8 | Pad input levels (asynchronous) |
| pad_oe | output | 8 | Pad output enable, 1 = drive |
| pad_out | output | 8 | Pad output data |
| wake_req | output | 1 | One-cycle wake request to the power controller |

## Verification
Register writes take effect on `pad_oe` and `pad_out` one edge after the write, and the bench samples them at the next falling clock edge. Read data is combinational, so it is sampled while the strobe is held and before the edge that clears the flags. A pad change reaches read data and `wake_req` after two rising edges. The bench therefore waits exactly two cycles after driving a pad, checks that the request is high, then steps once more and checks that it has dropped. It reads the flags only after the third edge, the one that sets them. The set-versus-clear case issues the read in the very cycle in which the event is active.

// File: rtl/gpio_wake_pkg.sv
// Shared register address encoding for the GPIO wake port.
package gpio_wake_pkg;
    typedef enum logic [1:0] {
        REG_DATA = 2'd0,
        REG_DIR  = 2'd1,
        REG_WEN  = 2'd2,
        REG_WSRC = 2'd3
    } gpio_reg_e;
endpackage

// File: rtl/gpio_sync.sv
// Two-flop synchronizer for a vector of asynchronous pad inputs.
// Assumes each bit is independent (no bus coherency needed); resets to
// RST_VAL so that idle-high pads give no edge after reset.
module gpio_sync #(
    parameter int          WIDTH   = 8,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] meta_q;

    // Shift the pad levels through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q   <= RST_VAL;
            sync_out <= RST_VAL;
        end else begin
            meta_q   <= async_in;
            sync_out <= meta_q;
        end
    end
endmodule

// File: rtl/gpio_edge_detect.sv
// Per-bit edge detector on synchronized inputs. Every bit reports falling
// edges; bits set in DUAL_MASK also report rising edges. Events last one
// cycle, the cycle in which the synchronized value first differs from the
// value held one clock earlier.
module gpio_edge_detect #(
    parameter int               WIDTH     = 8,
    parameter logic [WIDTH-1:0] DUAL_MASK = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] sync_in,
    output logic [WIDTH-1:0] evt
);
    logic [WIDTH-1:0] prev_q;
    logic [WIDTH-1:0] fall;
    logic [WIDTH-1:0] rise;

    // Remember the previous synchronized level.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= sync_in;
    end

    assign fall = prev_q & ~sync_in;
    assign rise = ~prev_q & sync_in;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (DUAL_MASK[i]) begin : g_dual
            assign evt[i] = fall[i] | rise[i];
        end else begin : g_single
            assign evt[i] = fall[i];
        end
    end

    // R4: a falling event never lasts two cycles on the same bit.
    a_r4_fall_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (|fall) |=> ((fall & $past(fall)) == '0));
endmodule

// File: rtl/gpio_wake_port.sv
// GPIO port with register access, halt wake-up and dual-edge source flags.
// Assumes: combinational read data, side effects on the clock edge, pads
// idle high during reset, and halt driven synchronously by the power
// controller.
module gpio_wake_port
    import gpio_wake_pkg::*;
#(
    parameter int WIDTH  = 8,
    parameter int DUAL_A = 4,
    parameter int DUAL_B = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       addr,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    input  logic             halt,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] pad_out,
    output logic             wake_req
);
    localparam int NDUAL = 2;
    localparam int DUAL_IDX [NDUAL] = '{DUAL_A, DUAL_B};
    localparam logic [WIDTH-1:0] DUAL_MASK =
        (WIDTH'(1) << DUAL_A) | (WIDTH'(1) << DUAL_B);

    logic [WIDTH-1:0] data_q, dir_q, wen_q;
    logic [NDUAL-1:0] wsrc_q, wsrc_set;
    logic [WIDTH-1:0] pin_sync, evt, wake_evt;
    logic             wsrc_clr;

    gpio_sync #(.WIDTH(WIDTH), .RST_VAL('1)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(pad_in), .sync_out(pin_sync)
    );

    gpio_edge_detect #(.WIDTH(WIDTH), .DUAL_MASK(DUAL_MASK)) u_edge (
        .clk(clk), .rst_n(rst_n), .sync_in(pin_sync), .evt(evt)
    );

    // Enabled edges that count while halted.
    assign wake_evt = halt ? (evt & wen_q) : '0;
    assign wake_req = |wake_evt;

    for (genvar d = 0; d < NDUAL; d++) begin : g_src
        assign wsrc_set[d] = wake_evt[DUAL_IDX[d]];
    end
    assign wsrc_clr = rd_en && (addr == REG_WSRC);

    // Configuration registers, written from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '1;
            dir_q  <= '1;
            wen_q  <= '0;
        end else if (wr_en) begin
            case (addr)
                REG_DATA: data_q <= wr_data;
                REG_DIR:  dir_q  <= wr_data;
                REG_WEN:  wen_q  <= wr_data;
                default:  ;
            endcase
        end
    end

    // Sticky wake-source flags: clear on read, a new event wins.
    always_ff @(posedge clk) begin
        if (!rst_n) wsrc_q <= '0;
        else        wsrc_q <= (wsrc_q & ~{NDUAL{wsrc_clr}}) | wsrc_set;
    end

    // Read mux: latch for outputs, pin level for inputs.
    always_comb begin
        case (addr)
            REG_DATA: rd_data = (data_q & ~dir_q) | (pin_sync & dir_q);
            REG_DIR:  rd_data = dir_q;
            REG_WEN:  rd_data = wen_q;
            default:  rd_data = WIDTH'(wsrc_q);
        endcase
    end

    assign pad_oe  = ~dir_q;
    assign pad_out = data_q;

    // R1: a direction write shows on the pad enables the next cycle.
    a_r1_dir_to_oe: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == REG_DIR) |=> (pad_oe == ~$past(wr_data)));
    // R2: reset leaves every pin an input with the latch high.
    a_r2_reset_state: assert property (@(posedge clk)
        (!rst_n) |=> (pad_oe == '0 && pad_out == '1 && wsrc_q == '0));
    // R6 / R8: an event from a dual pin always leaves its flag set.
    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|wsrc_set) |=> ((wsrc_q & $past(wsrc_set)) == $past(wsrc_set)));
    // R7: a flag read with no new event leaves the flags empty.
    a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == REG_WSRC && wsrc_set == '0) |=> (wsrc_q == '0));
endmodule

// File: tb/test_gpio_wake_port.sv
module test_gpio_wake_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] addr = '0;
    logic       wr_en = 1'b0, rd_en = 1'b0, halt = 1'b0;
    logic [7:0] wr_data = '0, pad_in = 8'hFF;
    logic [7:0] rd_data, pad_oe, pad_out;
    logic       wake_req;
    int         n_chk = 0, n_bad = 0;
    logic [7:0] v;

    gpio_wake_port i_gpio_wake_port (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .halt(halt), .pad_in(pad_in),
        .pad_oe(pad_oe), .pad_out(pad_out), .wake_req(wake_req)
    );

    always #4 clk = ~clk;   // 125 MHz

    // {write, addr, data, pad, expect}; addr 0 data, 1 dir, 2 wake en, 3 flags
    localparam int NV = 11;
    localparam logic [26:0] VEC [NV] = '{
        {1'b1, 2'd1, 8'h0F, 8'hFF, 8'h00},  // R1 upper nibble outputs
        {1'b1, 2'd0, 8'hA5, 8'hFF, 8'h00},  // R1 latch
        {1'b0, 2'd0, 8'h00, 8'h3C, 8'hAC},  // R3 mixed read
        {1'b1, 2'd1, 8'hF0, 8'h3C, 8'h00},  // R1 lower nibble outputs
        {1'b0, 2'd0, 8'h00, 8'h3C, 8'h35},  // R3 mixed read
        {1'b1, 2'd1, 8'hFF, 8'h96, 8'h00},  // R1 all inputs
        {1'b0, 2'd0, 8'h00, 8'h96, 8'h96},  // R3 pin levels
        {1'b0, 2'd1, 8'h00, 8'hFF, 8'hFF},  // R1 direction readback
        {1'b1, 2'd2, 8'h81, 8'hFF, 8'h00},  // R4 wake enable
        {1'b0, 2'd2, 8'h00, 8'hFF, 8'h81},  // R4 readback
        {1'b0, 2'd3, 8'h00, 8'hFF, 8'h00}   // R6 no flags
    };

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        addr = a; wr_data = d; wr_en = 1'b1;
        step();
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [7:0] d);
        addr = a; rd_en = 1'b1;
        #1 d = rd_data;
        step();
        rd_en = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk); step(); step();
        rst_n = 1'b1;
        // R2 reset state
        check("R2 pad_oe", pad_oe, 8'h00);
        check("R2 pad_out", pad_out, 8'hFF);
        check("R2 wake_req", {7'd0, wake_req}, 8'h00);
        rd(2'd1, v); check("R2 dir", v, 8'hFF);
        rd(2'd2, v); check("R2 wake en", v, 8'h00);

        for (int k = 0; k < NV; k++) begin
            pad_in = VEC[k][15:8];
            if (VEC[k][26]) begin
                wr(VEC[k][25:24], VEC[k][23:16]);
            end else begin
                step(); step();
                rd(VEC[k][25:24], v);
                check($sformatf("R%0d vector %0d", (VEC[k][25:24] == 2'd0) ? 3 : 4, k), v, VEC[k][7:0]);
            end
        end

        // R1 pad controls after a write
        wr(2'd1, 8'h0F);
        check("R1 pad_oe", pad_oe, 8'hF0);
        wr(2'd0, 8'h5A);
        check("R1 pad_out", pad_out, 8'h5A);
        wr(2'd1, 8'hFF);

        // R4 single-edge pin 0
        pad_in = 8'hFF; wr(2'd2, 8'h01); halt = 1'b1; step(); step();
        pad_in = 8'hFE; step(); step();
        check("R4 wake on fall", {7'd0, wake_req}, 8'h01);
        step();
        check("R4 wake one cycle", {7'd0, wake_req}, 8'h00);
        pad_in = 8'hFF; step(); step();
        check("R4 no wake on rise", {7'd0, wake_req}, 8'h00);
        step();
        pad_in = 8'hFD; step(); step();
        check("R4 disabled pin", {7'd0, wake_req}, 8'h00);
        pad_in = 8'hFF; step(); step(); step();
        halt = 1'b0; pad_in = 8'hFE; step(); step();
        check("R4 not halted", {7'd0, wake_req}, 8'h00);
        pad_in = 8'hFF; step(); step(); step();
        rd(2'd3, v); check("R6 single pin sets no flag", v, 8'h00);

        // R5 / R6 / R7 rising edge on dual pin 4
        wr(2'd2, 8'h30);
        pad_in = 8'hEF; step(); step(); step();
        halt = 1'b1;
        pad_in = 8'hFF; step(); step();
        check("R5 wake on rise", {7'd0, wake_req}, 8'h01);
        step();
        rd(2'd3, v); check("R6 flag for pin 4", v, 8'h01);
        rd(2'd3, v); check("R7 cleared by read", v, 8'h00);

        // R8 event and flag read in the same cycle
        pad_in = 8'hDF; step(); step();
        check("R5 wake on fall pin 5", {7'd0, wake_req}, 8'h01);
        rd(2'd3, v); check("R8 read before set", v, 8'h00);
        rd(2'd3, v); check("R8 flag survives", v, 8'h02);

        // R9 writes to the flag register are ignored
        pad_in = 8'hCF; step(); step(); step();
        wr(2'd3, 8'h00);
        rd(2'd3, v); check("R9 write does not clear", v, 8'h01);
        wr(2'd3, 8'hFF);
        rd(2'd3, v); check("R9 write does not set", v, 8'h00);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule